// File: doc/BRIEF.md
# Two-Slot Context Submission Tracker

This block follows the command-context submissions of a single engine. A submission is a pair of 64-bit context descriptors. Each submission is stored in one of two slots. The block records which slot is running, whether the other slot holds a queued (pending) submission, and which of the two elements in the running slot is active. Software-side logic sends it two kinds of request. A schedule-in carries a new descriptor pair. A schedule-out names the context that has just finished. For each request the block updates a 64-bit status word and emits zero, one or two context-status events to a downstream status-buffer writer.

Requests use a valid/ready handshake and are taken one at a time. Events leave through a second valid/ready stream, in order, and each event carries a flag that tells the writer to hold back its interrupt. An event stays on the outputs, unchanged, until the writer takes it. While any event from an earlier request is still waiting, `req_ready` stays low. A stalled event stream therefore holds back new requests rather than dropping events. A request the block cannot honour produces a one-cycle error pulse and changes nothing.

Top module: `subq_tracker`

## Requirements
- R1: After reset the status word is all zero, `req_ready` is high, `evt_valid` is low and no slot is running or pending.
- R2: A descriptor has its context ID in bits 63:32, its valid flag in bit 0 and its context address in bits 31:12. Two descriptors count as the same context only when both the ID and the address agree; bits 11:1 play no part in the comparison.
- R3: `req_op` 0 is a schedule-in, and its pair is stored in the slot named by status bit 1 (write pointer). A schedule-in while status bit 2 (queue full) is set is rejected and leaves the state unchanged.
- R4: A schedule-in while idle makes the chosen slot the running slot with element 0 active. It emits one event with flag bit 0 (idle-to-active) and context ID 0.
- R5: A schedule-in while running is a lite restore in two cases. In the first, element 1 of the running slot is valid and matches the new element 0, and element 1 is the active one. In the second, element 1 is invalid and element 0 matches the new element 0. The new slot then runs from element 0, and the block emits one event with flag bits 15 (lite restore) and 1 (preempted), carrying the new element 0 ID.
- R6: Any other accepted schedule-in becomes the pending slot, emits no event, and sets status bit 2.
- R7: `req_op` 1 is a schedule-out. A schedule-out of the active element 0 while element 1 is valid makes element 1 active. It emits one event with flag bits 4 (complete) and 2 (element switch), carrying the finished ID.
- R8: A schedule-out of the last valid element emits a complete event with flag bits 4 and 3 (active-to-idle). If a slot is pending, that event has its defer flag set, the pending slot runs from element 0, and an idle-to-active event with ID 0 follows. With no slot pending, the block goes idle.
- R9: A schedule-out while idle, or one that names a context other than the active one, is rejected and leaves the state unchanged with no event.
- R10: Status low word layout: bit 0 is the running slot index, bit 1 its inverse, bit 2 is pending present, bits 3 and 17 are set for slot 1 running, and bits 4 and 18 are set for slot 0 running. Bits 63:32 hold the active context ID. When idle, the valid and active bits and the upper word are zero, and bits 1:0 keep their last values.
- R11: Events leave in order, each held stable while `evt_ready` is low, with `evt_word` = {ID, flags}. `req_ready` is low while any event is queued.
- R12: `req_err` is high for exactly the one cycle after a rejected request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_op | input | 1 | 0 schedule-in, 1 schedule-out |
| req_desc0 | input | 64 | Element 0 descriptor, or finished context for schedule-out |
| req_desc1 | input | 64 | Element 1 descriptor (schedule-in only) |
| req_err | output | 1 | One-cycle pulse after a rejected request |
| trk_status | output | 64 | Status word |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Writer takes the event |
| evt_word | output | 64 | Event: ID in 63:32, flags in 31:0 |
| evt_defer | output | 1 | Writer holds back the interrupt for this event |

## Verification
On every cycle the assertions check several properties. A pending slot always implies a running slot in the other index. At most one slot's valid bit is set. A rejected request leaves the status word unchanged. Every start from idle has an event queued. A stalled event holds its value. Whether each request is classified correctly is only visible in the bench's scenarios: lite restore against pending, element switch against last element, and the deferred interrupt followed by idle-to-active. The bench compares event order, contents and the status word against an independent model across directed and random request sequences.

// File: rtl/subq_pkg.sv
package subq_pkg;

  localparam int DESC_W   = 64;
  localparam int CID_W    = 32;
  localparam int FLAG_W   = 32;
  localparam int ADDR_LSB = 12;

  // event flag bit positions
  localparam int EV_START   = 0;
  localparam int EV_PREEMPT = 1;
  localparam int EV_ESWITCH = 2;
  localparam int EV_TOIDLE  = 3;
  localparam int EV_DONE    = 4;
  localparam int EV_LITE    = 15;

  // status bit positions
  localparam int ST_CUR   = 0;
  localparam int ST_WR    = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_V1    = 3;
  localparam int ST_V0    = 4;
  localparam int ST_A1    = 17;
  localparam int ST_A0    = 18;

  typedef struct packed {
    logic [CID_W-1:0] cid;
    logic [31:0]      ctl;
  } desc_t;

  typedef struct packed {
    logic              defer;
    logic [CID_W-1:0]  cid;
    logic [FLAG_W-1:0] flags;
  } evt_t;

  typedef struct packed {
    logic run_vld;
    logic run_idx;
    logic pend_vld;
    logic pend_idx;
    logic act;
    logic ptr_cur;
    logic ptr_wr;
  } trk_t;

  typedef enum logic {OP_IN = 1'b0, OP_OUT = 1'b1} op_e;

  function automatic logic desc_live(desc_t d);
    return d.ctl[0];
  endfunction

  function automatic logic same_ctx(desc_t a, desc_t b);
    return (a.cid == b.cid) && (a.ctl[31:ADDR_LSB] == b.ctl[31:ADDR_LSB]);
  endfunction

endpackage

// File: rtl/subq_decide.sv
module subq_decide
  import subq_pkg::*;
(
  input  trk_t               cur,
  input  desc_t [1:0][1:0]   slot_q,
  input  logic               op,
  input  desc_t              nd0,
  output trk_t               nxt,
  output logic               wr_en,
  output logic               wr_idx,
  output logic               err,
  output logic [1:0]         n_evt,
  output evt_t               ev0,
  output evt_t               ev1
);

  desc_t e0, e1, act_d;
  logic  lite_hit;

  always_comb begin
    e0    = slot_q[cur.run_idx][0];
    e1    = slot_q[cur.run_idx][1];
    act_d = cur.act ? e1 : e0;
    lite_hit = (desc_live(e1) && same_ctx(e1, nd0) && cur.act) ||
               (!desc_live(e1) && same_ctx(e0, nd0));
  end

  always_comb begin
    nxt    = cur;
    wr_en  = 1'b0;
    wr_idx = cur.ptr_wr;
    err    = 1'b0;
    n_evt  = 2'd0;
    ev0    = '0;
    ev1    = '0;
    if (op == OP_IN) begin
      if (cur.pend_vld) begin
        err = 1'b1;
      end else begin
        wr_en = 1'b1;
        if (!cur.run_vld) begin
          nxt.run_vld = 1'b1;
          nxt.run_idx = cur.ptr_wr;
          nxt.act     = 1'b0;
          n_evt       = 2'd1;
          ev0.flags[EV_START] = 1'b1;
        end else if (lite_hit) begin
          nxt.run_idx = cur.ptr_wr;
          nxt.act     = 1'b0;
          n_evt       = 2'd1;
          ev0.flags[EV_LITE]    = 1'b1;
          ev0.flags[EV_PREEMPT] = 1'b1;
          ev0.cid     = nd0.cid;
        end else begin
          nxt.pend_vld = 1'b1;
          nxt.pend_idx = cur.ptr_wr;
        end
      end
    end else begin
      if (!cur.run_vld || !same_ctx(nd0, act_d)) begin
        err = 1'b1;
      end else if (!cur.act && desc_live(e1)) begin
        nxt.act = 1'b1;
        n_evt   = 2'd1;
        ev0.flags[EV_DONE]    = 1'b1;
        ev0.flags[EV_ESWITCH] = 1'b1;
        ev0.cid = nd0.cid;
      end else if (cur.act == desc_live(e1)) begin
        ev0.flags[EV_DONE]   = 1'b1;
        ev0.flags[EV_TOIDLE] = 1'b1;
        ev0.cid   = nd0.cid;
        nxt.act   = 1'b0;
        if (cur.pend_vld) begin
          ev0.defer    = 1'b1;
          ev1.flags[EV_START] = 1'b1;
          n_evt        = 2'd2;
          nxt.run_idx  = cur.pend_idx;
          nxt.pend_vld = 1'b0;
        end else begin
          n_evt       = 2'd1;
          nxt.run_vld = 1'b0;
        end
      end else begin
        err = 1'b1;
      end
    end
    if (nxt.run_vld) begin
      nxt.ptr_cur = nxt.run_idx;
      nxt.ptr_wr  = ~nxt.run_idx;
    end
  end

endmodule

// File: rtl/subq_status.sv
module subq_status
  import subq_pkg::*;
(
  input  trk_t              st,
  input  logic [CID_W-1:0]  act_cid,
  output logic [63:0]       status
);

  always_comb begin
    status = '0;
    if (st.run_vld) begin
      status[ST_CUR] = st.run_idx;
      status[ST_WR]  = ~st.run_idx;
      status[ST_V1]  = st.run_idx;
      status[ST_A1]  = st.run_idx;
      status[ST_V0]  = ~st.run_idx;
      status[ST_A0]  = ~st.run_idx;
      status[63:32]  = act_cid;
    end else begin
      status[ST_CUR] = st.ptr_cur;
      status[ST_WR]  = st.ptr_wr;
    end
    status[ST_FULL] = st.pend_vld;
  end

endmodule

// File: rtl/subq_evt_fifo.sv
module subq_evt_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   push_n,
  input  logic [W-1:0] push0,
  input  logic [W-1:0] push1,
  output logic         room2,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          pop;

  function automatic logic [AW-1:0] nx(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign pop       = out_valid && out_ready;
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign room2     = (cnt <= CW'(DEPTH - 2));

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= push0;
    if (push_n == 2'd2) mem[nx(wp)] <= push1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push_n == 2'd2)      wp <= nx(nx(wp));
      else if (push_n == 2'd1) wp <= nx(wp);
      if (pop) rp <= nx(rp);
      cnt <= cnt + CW'(push_n) - CW'(pop);
    end
  end

  // R11
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R11
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/subq_tracker.sv
module subq_tracker
  import subq_pkg::*;
#(
  parameter int EVT_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_op,
  input  logic [63:0] req_desc0,
  input  logic [63:0] req_desc1,
  output logic        req_err,
  output logic [63:0] trk_status,
  output logic        evt_valid,
  input  logic        evt_ready,
  output logic [63:0] evt_word,
  output logic        evt_defer
);

  localparam int EVT_W = $bits(evt_t);

  trk_t             st_q, st_nxt;
  desc_t [1:0][1:0] slot_q;
  logic             acc, dec_err, wr_en, wr_idx, room2;
  logic [1:0]       dec_n, push_n;
  evt_t             ev0, ev1, ev_out;
  logic [CID_W-1:0] act_cid;

  assign acc       = req_valid && req_ready;
  assign req_ready = room2;
  assign push_n    = acc ? dec_n : 2'd0;
  assign act_cid   = slot_q[st_q.run_idx][st_q.act].cid;

  subq_decide u_dec (
    .cur    (st_q),
    .slot_q (slot_q),
    .op     (req_op),
    .nd0    (desc_t'(req_desc0)),
    .nxt    (st_nxt),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .err    (dec_err),
    .n_evt  (dec_n),
    .ev0    (ev0),
    .ev1    (ev1)
  );

  subq_status u_st (
    .st      (st_q),
    .act_cid (act_cid),
    .status  (trk_status)
  );

  subq_evt_fifo #(.W(EVT_W), .DEPTH(EVT_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (push_n),
    .push0     (ev0),
    .push1     (ev1),
    .room2     (room2),
    .out_valid (evt_valid),
    .out_ready (evt_ready),
    .out_data  (ev_out)
  );

  assign evt_word  = {ev_out.cid, ev_out.flags};
  assign evt_defer = ev_out.defer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      slot_q  <= '0;
      req_err <= 1'b0;
    end else begin
      req_err <= acc && dec_err;
      if (acc) st_q <= st_nxt;
      if (acc && wr_en) begin
        slot_q[wr_idx][0] <= desc_t'(req_desc0);
        slot_q[wr_idx][1] <= desc_t'(req_desc1);
      end
    end
  end

  // R6
  pend_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.pend_vld |-> st_q.run_vld);

  // R3
  pend_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.pend_vld |-> (st_q.pend_idx != st_q.run_idx));

  // R10
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trk_status[ST_V1], trk_status[ST_V0]}));

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $stable(trk_status));

  // R4
  start_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.run_vld) |-> (!st_q.act && evt_valid));

endmodule

// File: tb/subq_tracker_test.sv
`timescale 1ns/1ps
module subq_tracker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [63:0] req_desc0 = '0;
  logic [63:0] req_desc1 = '0;
  logic        req_err;
  logic [63:0] trk_status;
  logic        evt_valid;
  logic        evt_ready = 1'b0;
  logic [63:0] evt_word;
  logic        evt_defer;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  subq_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_desc0(req_desc0), .req_desc1(req_desc1), .req_err(req_err),
    .trk_status(trk_status),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_word(evt_word), .evt_defer(evt_defer)
  );

  // reference model state
  logic [63:0] m_slot [2][2];
  bit m_run, m_ridx, m_pend, m_pidx, m_act, m_cur, m_wr;
  logic [64:0] exp_q [4];
  int  exp_n;
  bit  exp_err;

  task automatic chk(bit ok, string rq, logic [64:0] act, logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit same(logic [63:0] a, logic [63:0] b);
    return (a[63:32] == b[63:32]) && (a[31:12] == b[31:12]);
  endfunction

  function automatic logic [63:0] mk(int cid, int ad, bit v, int mid);
    return {32'(cid), 20'(ad), 11'(mid), v};
  endfunction

  function automatic logic [63:0] mstat();
    logic [63:0] s = '0;
    if (m_run) begin
      s[0] = m_ridx; s[1] = !m_ridx;
      s[3] = m_ridx; s[17] = m_ridx;
      s[4] = !m_ridx; s[18] = !m_ridx;
      s[63:32] = m_slot[m_ridx][m_act][63:32];
    end else begin
      s[0] = m_cur; s[1] = m_wr;
    end
    s[2] = m_pend;
    return s;
  endfunction

  task automatic push_exp(logic [31:0] flags, logic [31:0] cid, bit dfr);
    exp_q[exp_n] = {dfr, cid, flags};
    exp_n++;
  endtask

  task automatic model_apply(bit op, logic [63:0] a, logic [63:0] b);
    logic [63:0] e0, e1, ad;
    bit w;
    exp_n = 0; exp_err = 0;
    e0 = m_slot[m_ridx][0];
    e1 = m_slot[m_ridx][1];
    ad = m_act ? e1 : e0;
    w  = m_wr;
    if (!op) begin
      if (m_pend) exp_err = 1;
      else begin
        m_slot[w][0] = a; m_slot[w][1] = b;
        if (!m_run) begin
          m_run = 1; m_ridx = w; m_act = 0;
          push_exp(32'h1, 32'h0, 0);
        end else if ((e1[0] && same(e1, a) && m_act) || (!e1[0] && same(e0, a))) begin
          m_ridx = w; m_act = 0;
          push_exp(32'h8002, a[63:32], 0);
        end else begin
          m_pend = 1; m_pidx = w;
        end
      end
    end else begin
      if (!m_run || !same(a, ad)) exp_err = 1;
      else if (!m_act && e1[0]) begin
        m_act = 1;
        push_exp(32'h14, a[63:32], 0);
      end else if (m_act == e1[0]) begin
        push_exp(32'h18, a[63:32], m_pend);
        m_act = 0;
        if (m_pend) begin
          m_ridx = m_pidx; m_pend = 0;
          push_exp(32'h1, 32'h0, 0);
        end else m_run = 0;
      end else exp_err = 1;
    end
    if (m_run) begin m_cur = m_ridx; m_wr = !m_ridx; end
  endtask

  task automatic drain(string tag);
    int got = 0;
    int guard = 0;
    logic [64:0] held = '0;
    bit stalled = 0;
    if (exp_n > 0) chk(req_ready == 0, "R11 ready low while events queued", 65'(req_ready), 65'(0));
    while (got < exp_n && guard < 200) begin
      guard++;
      evt_ready = ($urandom % 3) != 0;
      if (stalled && evt_valid)
        chk({evt_defer, evt_word} == held, "R11 event held during stall", {evt_defer, evt_word}, held);
      stalled = 0;
      if (evt_valid && evt_ready) begin
        chk({evt_defer, evt_word} == exp_q[got], {tag, " event"}, {evt_defer, evt_word}, exp_q[got]);
        got++;
      end else if (evt_valid) begin
        stalled = 1;
        held = {evt_defer, evt_word};
      end
      @(negedge clk);
    end
    evt_ready = 0;
    chk(got == exp_n, "R11 event count", 65'(got), 65'(exp_n));
    chk(evt_valid == 0, "R11 no surplus event", 65'(evt_valid), 65'(0));
  endtask

  task automatic do_req(bit op, logic [63:0] a, logic [63:0] b, string tag);
    model_apply(op, a, b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_desc0 = a; req_desc1 = b;
    @(negedge clk);
    req_valid = 0;
    chk(req_err == exp_err, {tag, " R12 error pulse"}, 65'(req_err), 65'(exp_err));
    chk(trk_status == mstat(), {tag, " R10 status"}, 65'(trk_status), 65'(mstat()));
    @(negedge clk);
    chk(req_err == 0, "R12 error lasts one cycle", 65'(req_err), 65'(0));
    drain(tag);
  endtask

  function automatic logic [63:0] pick_desc();
    return mk($urandom_range(1, 4), 'h100 + $urandom_range(0, 1),
              ($urandom % 4) != 0, $urandom % 2048);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] A, B, C, D, C2, X, E, F, G, a, b;
    void'($urandom(32'd4242));
    m_run = 0; m_ridx = 0; m_pend = 0; m_pidx = 0; m_act = 0; m_cur = 0; m_wr = 0;
    for (int i = 0; i < 2; i++) for (int j = 0; j < 2; j++) m_slot[i][j] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(trk_status == 64'h0, "R1 reset status", 65'(trk_status), 65'(0));
    chk(req_ready == 1, "R1 reset ready", 65'(req_ready), 65'(1));
    chk(evt_valid == 0, "R1 reset no event", 65'(evt_valid), 65'(0));

    A  = mk(1, 'h100, 1, 0);
    B  = mk(2, 'h100, 1, 0);
    C  = mk(3, 'h101, 1, 0);
    D  = mk(4, 'h101, 0, 0);
    C2 = mk(3, 'h101, 1, 'h3f0);
    X  = mk(5, 'h100, 0, 0);
    E  = mk(6, 'h102, 1, 0);
    F  = mk(7, 'h102, 1, 0);
    G  = mk(8, 'h102, 1, 0);

    do_req(1, A, '0, "R9 schedule-out while idle");
    do_req(0, A, B, "R4 start from idle");
    chk(trk_status == 64'h00000001_00040012, "R10 layout slot 0 running", 65'(trk_status), 65'h00000001_00040012);
    do_req(0, C, D, "R6 queued as pending");
    chk(trk_status == 64'h00000001_00040016, "R6 queue full bit", 65'(trk_status), 65'h00000001_00040016);
    do_req(0, E, F, "R3 reject when full");
    do_req(1, B, '0, "R9 out of non-active context");
    do_req(1, mk(1, 'h101, 1, 0), '0, "R2 address mismatch rejected");
    do_req(1, mk(1, 'h100, 1, 'h7ff), '0, "R7 element switch, R2 middle bits ignored");
    do_req(1, B, '0, "R8 last element with pending");
    chk(trk_status == 64'h00000003_00020009, "R10 layout slot 1 running", 65'(trk_status), 65'h00000003_00020009);
    do_req(0, C2, X, "R5 lite restore element 1 invalid");
    do_req(1, C, '0, "R8 last element to idle");
    chk(trk_status == 64'h00000000_00000002, "R10 idle keeps pointers", 65'(trk_status), 65'h2);
    do_req(0, E, F, "R4 start in slot 1");
    do_req(1, E, '0, "R7 switch to element 1");
    do_req(0, F, G, "R5 lite restore active element 1");

    for (int n = 0; n < 400; n++) begin
      bit op = $urandom % 2;
      if (op) begin
        if (m_run && ($urandom % 5) != 0) begin
          a = m_slot[m_ridx][m_act];
          a[11:1] = 11'($urandom);
        end else a = pick_desc();
        b = '0;
      end else begin
        b = pick_desc();
        if (m_run && ($urandom % 2) == 0) a = m_slot[m_ridx][$urandom % 2];
        else a = pick_desc();
      end
      do_req(op, a, b, "R3 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule